// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block computes a finite impulse response output without any multiplier. It keeps the most recent `TAPS` input samples in a delay line. For each new sample it forms the dot product of those samples with a fixed set of signed coefficients. The coefficients are given as a parameter. A constant table, generated at elaboration, holds the sum of every subset of the coefficients. On each clock of a pass, one bit taken from every stored sample addresses the table. Bits are taken from the most significant position down. A shift-accumulator doubles its running value and then adds the table word. It subtracts the word instead in the cycle where the two's complement sign bits form the address.

A host offers a sample with `in_valid`. The sample is taken only when the block is idle. Taking it starts one pass of `DW` cycles, and `busy` is high for the whole pass. When the pass ends, `y_out` carries the result and `out_valid` pulses for one cycle. `y_out` keeps that value until the next result.

The parameter `SPLIT` selects how the table is built. With `SPLIT` = 0 it is one table of 2^TAPS words. With `SPLIT` = 1 it is two tables of 2^(TAPS/2) words each, and an adder sums their outputs.

The control has two states:
- `ST_IDLE` waits for a sample. A valid sample causes the transition *accept*, which goes to `ST_RUN`.
- `ST_RUN` processes one bit position per clock. After the last bit position, the transition *finish* returns to `ST_IDLE`.

Top module: `dafir_top`

## Requirements
- R1: `y_out` equals the sum over k of coef[k]·x[k]. x[0] is the sample just accepted and x[k] is the sample accepted k passes earlier. Samples are `DW`-bit two's complement. Coefficient k is the signed `CW`-bit field at bits [k·CW +: CW] of `COEFS`.
- R2: `out_valid` is a one-cycle pulse. It comes `DW` clock edges after the edge that accepted the sample, and `y_out` is valid in that cycle.
- R3: `busy` is high for exactly the `DW` cycles of a pass. A sample offered while `busy` is high is ignored: it enters neither the delay line nor any result.
- R4: Each accepted sample becomes tap 0. Every older sample moves up one tap, and the sample in tap `TAPS`-1 is dropped.
- R5: The sign-bit cycle subtracts. A negative sample, including the most negative value -2^(DW-1), contributes with its correct sign.
- R6: A synchronous active-high `rst`, even in the middle of a pass, does four things: it clears the delay line to zeros, clears `y_out` to 0, clears `out_valid` to 0 and returns the block to idle.
- R7: `SPLIT` = 1 gives the same `y_out` as `SPLIT` = 0 for every input sequence.
- R8: Between result pulses, `y_out` holds the last result.
- R9: The accumulator has CW + clog2(TAPS) + DW bits, so full-scale inputs against extreme coefficients give the exact sum without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new sample is offered |
| in_sample | input | DW | Signed input sample |
| busy | output | 1 | A bit-serial pass is in progress |
| out_valid | output | 1 | One-cycle pulse: `y_out` holds a new result |
| y_out | output | CW+clog2(TAPS)+DW | Signed filter output |

## Verification
The checks that run every cycle cover the timing of the pass. They confirm the following:
- a pass never runs longer than `DW` cycles;
- each result pulse follows a pass of exactly `DW` cycles and lasts one cycle;
- an idle sample always starts a pass;
- the delay line stays unchanged while `busy` is high.

The numeric behaviour can only be shown by the bench's scenarios, run against a behavioural model. This covers the following:
- the exact dot product;
- tap order, shown by an impulse response;
- subtraction in the sign-bit cycle for the most negative sample;
- samples ignored while busy;
- reset in the middle of a pass;
- agreement between the split and the full table.

// File: rtl/dafir_pkg.sv
package dafir_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/dafir_tapline.sv
// Sample delay line plus per-tap shift registers that present bits MSB first.
module dafir_tapline #(
    parameter int TAPS = 4,
    parameter int DW   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 shift,
    input  logic [DW-1:0]        din,
    output logic [TAPS-1:0]      bits,
    output logic [TAPS*DW-1:0]   taps_flat
);
    logic [TAPS-1:0][DW-1:0] dline;
    logic [TAPS-1:0][DW-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            dline <= '0;
            sreg  <= '0;
        end else if (load) begin
            dline[0] <= din;
            sreg[0]  <= din;
            for (int k = 1; k < TAPS; k++) begin
                dline[k] <= dline[k-1];
                sreg[k]  <= dline[k-1];
            end
        end else if (shift) begin
            for (int k = 0; k < TAPS; k++) begin
                sreg[k] <= {sreg[k][DW-2:0], 1'b0};
            end
        end
    end

    always_comb begin
        for (int k = 0; k < TAPS; k++) begin
            bits[k] = sreg[k][DW-1];
        end
    end

    assign taps_flat = dline;
endmodule

// File: rtl/dafir_rom.sv
// Constant subset-sum table, either full or split into two half-address partitions.
module dafir_rom #(
    parameter int                  TAPS  = 4,
    parameter int                  CW    = 8,
    parameter bit                  SPLIT = 1'b0,
    parameter logic [TAPS*CW-1:0]  COEFS = '0,
    localparam int                 RW    = CW + $clog2(TAPS)
) (
    input  logic [TAPS-1:0]        addr,
    output logic signed [RW-1:0]   word
);
    function automatic logic signed [RW-1:0] subset_sum(input int lo, input int n, input int a);
        int s;
        s = 0;
        for (int i = 0; i < n; i++) begin
            if (a[i]) s = s + int'($signed(COEFS[(lo+i)*CW +: CW]));
        end
        return RW'(s);
    endfunction

    generate
        if (SPLIT && (TAPS >= 2) && (TAPS % 2 == 0)) begin : g_split
            localparam int H   = TAPS / 2;
            localparam int ENT = 1 << H;
            logic signed [RW-1:0] tbl_lo [ENT];
            logic signed [RW-1:0] tbl_hi [ENT];
            for (genvar e = 0; e < ENT; e++) begin : g_ent
                assign tbl_lo[e] = subset_sum(0, H, e);
                assign tbl_hi[e] = subset_sum(H, H, e);
            end
            assign word = tbl_lo[addr[H-1:0]] + tbl_hi[addr[TAPS-1:H]];
        end else begin : g_full
            localparam int ENT = 1 << TAPS;
            logic signed [RW-1:0] tbl [ENT];
            for (genvar e = 0; e < ENT; e++) begin : g_ent
                assign tbl[e] = subset_sum(0, TAPS, e);
            end
            assign word = tbl[addr];
        end
    endgenerate
endmodule

// File: rtl/dafir_shacc.sv
// Shift-accumulator: doubles the running value, then adds or subtracts the table word.
module dafir_shacc #(
    parameter int RW = 10,
    parameter int AW = 14
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  step,
    input  logic                  sub,
    input  logic signed [RW-1:0]  word,
    output logic signed [AW-1:0]  acc_nxt
);
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] word_x;

    assign word_x  = {{(AW-RW){word[RW-1]}}, word};
    assign acc_nxt = sub ? ((acc <<< 1) - word_x) : ((acc <<< 1) + word_x);

    always_ff @(posedge clk) begin
        if (rst || clr) acc <= '0;
        else if (step)  acc <= acc_nxt;
    end
endmodule

// File: rtl/dafir_top.sv
module dafir_top #(
    parameter int                  TAPS  = 4,
    parameter int                  DW    = 4,
    parameter int                  CW    = 8,
    parameter bit                  SPLIT = 1'b0,
    parameter logic [TAPS*CW-1:0]  COEFS = {8'shF9, 8'sh7F, 8'sh80, 8'sh5D},
    localparam int                 RW    = CW + $clog2(TAPS),
    localparam int                 AW    = RW + DW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [DW-1:0]         in_sample,
    output logic                  busy,
    output logic                  out_valid,
    output logic signed [AW-1:0]  y_out
);
    import dafir_pkg::*;

    localparam int CNTW = (DW > 1) ? $clog2(DW) : 1;

    run_state_t            state, state_nxt;
    logic [CNTW-1:0]       bitpos;
    logic                  last_bit, sign_phase, accept;
    logic [TAPS-1:0]       rom_addr;
    logic signed [RW-1:0]  rom_word;
    logic signed [AW-1:0]  acc_nxt;
    logic [TAPS*DW-1:0]    taps_flat;

    assign accept     = (state == ST_IDLE) && in_valid;
    assign last_bit   = (state == ST_RUN) && (bitpos == CNTW'(DW-1));
    assign sign_phase = (state == ST_RUN) && (bitpos == '0);
    assign busy       = (state == ST_RUN);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (accept)   state_nxt = ST_RUN;
            ST_RUN:  if (last_bit) state_nxt = ST_IDLE;
        endcase
    end

    // state register and bit-position counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            bitpos <= '0;
        end else begin
            state  <= state_nxt;
            bitpos <= (state == ST_RUN) ? bitpos + 1'b1 : '0;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            y_out     <= '0;
        end else begin
            out_valid <= last_bit;
            if (last_bit) y_out <= acc_nxt;
        end
    end

    dafir_tapline #(.TAPS(TAPS), .DW(DW)) u_taps (
        .clk(clk), .rst(rst), .load(accept), .shift(busy),
        .din(in_sample), .bits(rom_addr), .taps_flat(taps_flat)
    );

    dafir_rom #(.TAPS(TAPS), .CW(CW), .SPLIT(SPLIT), .COEFS(COEFS)) u_rom (
        .addr(rom_addr), .word(rom_word)
    );

    dafir_shacc #(.RW(RW), .AW(AW)) u_acc (
        .clk(clk), .rst(rst), .clr(accept), .step(busy),
        .sub(sign_phase), .word(rom_word), .acc_nxt(acc_nxt)
    );
endmodule

// File: rtl/dafir_chk.sv
module dafir_chk #(
    parameter int TAPS = 4,
    parameter int DW   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               busy,
    input logic               out_valid,
    input logic [TAPS*DW-1:0] taps_flat
);
    int run_len;

    always_ff @(posedge clk) begin
        if (rst)       run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    // R2: a pass never exceeds DW cycles
    p_pass_len_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < DW));

    // R2: a result follows a pass of exactly DW cycles
    p_result_after_pass_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (run_len == DW));

    // R2: the result flag is a single-cycle pulse
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R3: the delay line is frozen while a pass runs
    p_hold_taps_r3: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(taps_flat));

    // R3: an offered sample in idle always starts a pass
    p_accept_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && in_valid) |=> busy);
endmodule

bind dafir_top dafir_chk #(.TAPS(TAPS), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .busy(busy),
    .out_valid(out_valid), .taps_flat(taps_flat)
);

// File: tb/sim_dafir_top.sv
`timescale 1ns/1ps
module sim_dafir_top;
    localparam int TAPS = 4;
    localparam int DW   = 4;
    localparam int CW   = 8;
    localparam int AW   = CW + $clog2(TAPS) + DW;
    localparam logic [TAPS*CW-1:0] CF = {8'shF9, 8'sh7F, 8'sh80, 8'sh5D};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_sample = '0;
    logic busy, out_valid, busy1, out_valid1;
    logic signed [AW-1:0] y_out, y_out1;

    always #2.5 clk = ~clk;

    dafir_top #(.TAPS(TAPS), .DW(DW), .CW(CW), .SPLIT(1'b0), .COEFS(CF)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .busy(busy), .out_valid(out_valid), .y_out(y_out));

    dafir_top #(.TAPS(TAPS), .DW(DW), .CW(CW), .SPLIT(1'b1), .COEFS(CF)) u1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .busy(busy1), .out_valid(out_valid1), .y_out(y_out1));

    int checks = 0;
    int fails  = 0;
    int cf [TAPS] = '{93, -128, 127, -7};

    // behavioural reference model
    int q [TAPS];
    int m_busy = 0, m_cnt = 0, m_valid = 0, m_y = 0, m_pend = 0;
    bit started = 0;
    int cyc = 0;

    function automatic int sx(input logic [DW-1:0] v);
        return int'($signed(v));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            foreach (q[k]) q[k] = 0;
            m_busy = 0; m_cnt = 0; m_valid = 0; m_y = 0;
        end else begin
            m_valid = 0;
            if (m_busy != 0) begin
                m_cnt++;
                if (m_cnt == DW) begin
                    m_busy = 0; m_valid = 1; m_y = m_pend;
                end
            end else if (in_valid) begin
                for (int k = TAPS-1; k > 0; k--) q[k] = q[k-1];
                q[0] = sx(in_sample);
                m_pend = 0;
                for (int k = 0; k < TAPS; k++) m_pend += cf[k] * q[k];
                m_busy = 1; m_cnt = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            chk("R3 busy", int'(busy), m_busy);
            chk("R2 out_valid", int'(out_valid), m_valid);
            chk("R1 R8 y_out", int'(y_out), m_y);
            chk("R7 split y_out", int'(y_out1), int'(y_out));
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
            finish_run();
        end
    end

    int got;

    task automatic send(input int x);
        while (busy) @(negedge clk);
        in_valid = 1'b1; in_sample = DW'(x);
        @(negedge clk);
        in_valid = 1'b0;
        while (!out_valid) @(negedge clk);
        got = int'(y_out);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R6 reset state
        chk("R6 busy after reset", int'(busy), 0);
        chk("R6 out_valid after reset", int'(out_valid), 0);
        chk("R6 y_out after reset", int'(y_out), 0);

        // R4 impulse response shows tap order
        send(1);  chk("R4 tap0", got, 93);
        send(0);  chk("R4 tap1", got, -128);
        send(0);  chk("R4 tap2", got, 127);
        send(0);  chk("R4 tap3", got, -7);
        send(0);  chk("R4 oldest dropped", got, 0);

        // R5 most negative sample uses subtracting sign cycle
        send(-8); chk("R5 sign bit", got, -744);

        // R9 extreme values
        send(7); send(-8); send(7); send(-8);
        chk("R9 full scale", got, -2705);

        // R8 hold between results
        repeat (6) @(negedge clk);
        chk("R8 y_out held", int'(y_out), -2705);

        // R3 samples offered while busy are ignored
        in_valid = 1'b1; in_sample = DW'(2);
        @(negedge clk);
        in_sample = DW'(5);
        repeat (2) @(negedge clk);
        in_valid = 1'b0;
        while (!out_valid) @(negedge clk);
        send(0);
        chk("R3 ignored while busy", got, -1321);

        // R1 R2 back-to-back pseudo-random samples
        for (int i = 0; i < 40; i++) begin
            send(int'($urandom_range(0, 15)) - 8);
            chk("R1 random dot product", got, m_y);
        end

        // R6 reset in the middle of a pass
        in_valid = 1'b1; in_sample = DW'(3);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R6 busy after mid reset", int'(busy), 0);
        chk("R6 y_out after mid reset", int'(y_out), 0);
        send(1);
        chk("R6 delay line cleared", got, 93);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule